// File: doc/BRIEF.md
# Programmable Raster Sync Timing Generator

This block produces the horizontal and vertical timing of a raster display from a small set of registers written by software. A pixel counter runs along each line and a line counter advances once per line. Both counters are compared against programmed positions to produce a display-enable flag, a blanking flag, a pair of CRT sync pulses, and a second, separately timed pair of sync pulses meant for a flat panel. Each sync pair has its own polarity, set in software.

Every position is stored as the nominal value minus one. A start and an end share one 32-bit word. Writes go to shadow copies. The live copies that drive the comparators take the new values only at the first line of vertical blanking, or at any cycle while the generator is disabled. This allows software to retime a running display without tearing a frame. Typical uses are a 640x480 raster in an 832x520 total with active-low syncs, or 1280x1024 in 1688x1066 with active-high syncs.

Top module: `raster_timing_gen`

## Requirements
- R1: Words are written at `wr_addr` when `wr_en` is high. Addresses 1 to 4 hold the horizontal descriptors and addresses 5 to 8 the vertical descriptors, in the per-axis order size, blanking, CRT sync, flat-panel sync. In each word, bits [10:0] hold the low value (active count or start, minus one) and bits [26:16] hold the high value (total or end, minus one). A write to any address above 8 changes nothing.
- R2: Address 0 is the control word. Bit 0 enables the generator. Bit 4 selects HSYNC polarity and bit 5 selects VSYNC polarity, where 1 means active-low and 0 means active-high. These bits apply to both sync pairs and take effect on the next clock.
- R3: While enabled, the pixel counter counts 0, 1, … up to the live stored total, then returns to 0.
- R4: The line counter advances only when the pixel counter wraps, and it returns to 0 after reaching its own live stored total.
- R5: `de_o` is high when the pixel count is at or below the stored horizontal active value and the line count is at or below the stored vertical active value.
- R6: `blank_o` is high when, on either axis, the count is above the stored blank start and at or below the stored blank end.
- R7: A CRT sync is active while its counter is at or above the stored sync start and strictly below the stored sync end. The polarity bit is applied after this comparison.
- R8: The flat-panel syncs use the same window rule, but with their own descriptor words. Each word is honoured literally, so a vertical flat-panel word loaded one line lower than the CRT word makes the flat-panel pulse lead the CRT pulse by exactly one line.
- R9: Descriptor writes have no effect on the outputs until the line counter steps to (stored vertical blank start + 1). At that step, all shadow descriptors move to the live set at once. While the generator is disabled, the live set follows the shadows every cycle.
- R10: While disabled, both counters are held at 0, `de_o` and `blank_o` are low, and all four syncs sit at their inactive level.
- R11: All outputs are registered. In each cycle they describe the same counter position, one clock after the counter takes it. Reset clears all registers, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register word address |
| wr_data | input | DW (32) | Register write data |
| hcount_o | output | 11 | Pixel position within the line |
| vcount_o | output | 11 | Line position within the frame |
| de_o | output | 1 | Visible region flag |
| blank_o | output | 1 | Blanking flag |
| hsync_o | output | 1 | CRT horizontal sync, polarity applied |
| vsync_o | output | 1 | CRT vertical sync, polarity applied |
| fp_hsync_o | output | 1 | Flat-panel horizontal sync, polarity applied |
| fp_vsync_o | output | 1 | Flat-panel vertical sync, polarity applied |

## Verification
The bench targets these corner cases:
- **Half-open sync window.** In the 640-wide mode, a pulse one pixel too long or too short shows that a comparator treated the end bound as inclusive or the start bound as exclusive.
- **Mid-frame descriptor change.** A new line length is written in the middle of a frame. A design without proper shadowing would stretch the current line at once, instead of waiting for blanking.
- **Flat-panel vertical word one line lower.** The bench counts the cycles in which only the flat-panel pulse is active. A design that routed the CRT word to both pairs would show zero such cycles instead of one line.
- **Polarity, disable, and ignored addresses.** Flipping polarity, disabling the generator, and writing to unused addresses would expose a swapped polarity bit, a counter that keeps running while disabled, or an address decode that aliases.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int unsigned CW        = 11;
  localparam int unsigned NAX       = 2;
  localparam int unsigned NKIND     = 4;
  localparam int unsigned HI_LSB    = 16;
  localparam int unsigned K_SIZE    = 0;
  localparam int unsigned K_BLANK   = 1;
  localparam int unsigned K_SYNC    = 2;
  localparam int unsigned K_FP      = 3;
  localparam int unsigned CTRL_EN   = 0;
  localparam int unsigned CTRL_POL  = 4;

  typedef logic [CW-1:0] pos_t;

  typedef struct packed {
    pos_t act;
    pos_t tot;
    pos_t bs;
    pos_t be;
    pos_t ss;
    pos_t se;
    pos_t fs;
    pos_t fe;
  } axis_cfg_t;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DW-1:0]        wr_data,
  input  logic                 load,
  output logic                 ctrl_en,
  output logic [1:0]           pol,
  output axis_cfg_t [NAX-1:0]  live
);
  localparam int unsigned NSLOT = NAX * NKIND;

  logic [NSLOT*CW-1:0]  lo_flat;
  logic [NSLOT*CW-1:0]  hi_flat;
  axis_cfg_t [NAX-1:0]  shadow;
  logic                 unused_bits;

  assign unused_bits = ^{wr_data[DW-1:HI_LSB+CW], wr_data[HI_LSB-1:CW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en <= 1'b0;
      pol     <= 2'b00;
    end else if (wr_en && wr_addr == '0) begin
      ctrl_en <= wr_data[CTRL_EN];
      pol     <= wr_data[CTRL_POL +: 2];
    end
  end

  for (genvar a = 0; a < NAX; a++) begin : g_ax
    for (genvar k = 0; k < NKIND; k++) begin : g_kind
      localparam int unsigned SLOT = a * NKIND + k;
      pos_t lo_q, hi_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          lo_q <= '0;
          hi_q <= '0;
        end else if (wr_en && wr_addr == ADDR_W'(SLOT + 1)) begin
          lo_q <= wr_data[CW-1:0];
          hi_q <= wr_data[HI_LSB +: CW];
        end
      end
      assign lo_flat[SLOT*CW +: CW] = lo_q;
      assign hi_flat[SLOT*CW +: CW] = hi_q;
    end
  end

  always_comb begin
    for (int a = 0; a < NAX; a++) begin
      shadow[a].act = lo_flat[(a*NKIND+K_SIZE)*CW  +: CW];
      shadow[a].tot = hi_flat[(a*NKIND+K_SIZE)*CW  +: CW];
      shadow[a].bs  = lo_flat[(a*NKIND+K_BLANK)*CW +: CW];
      shadow[a].be  = hi_flat[(a*NKIND+K_BLANK)*CW +: CW];
      shadow[a].ss  = lo_flat[(a*NKIND+K_SYNC)*CW  +: CW];
      shadow[a].se  = hi_flat[(a*NKIND+K_SYNC)*CW  +: CW];
      shadow[a].fs  = lo_flat[(a*NKIND+K_FP)*CW    +: CW];
      shadow[a].fe  = hi_flat[(a*NKIND+K_FP)*CW    +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       live <= '0;
    else if (load) live <= shadow;
  end
endmodule

// File: rtl/rtg_axis_counter.sv
module rtg_axis_counter #(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          step,
  input  logic [CW-1:0] tot,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  assign wrap = run && step && (cnt == tot);

  always_ff @(posedge clk) begin
    if (rst || !run)    cnt <= '0;
    else if (step) begin
      if (cnt == tot)   cnt <= '0;
      else              cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rtg_axis_cmp.sv
module rtg_axis_cmp
  import rtg_pkg::*;
(
  input  pos_t      cnt,
  input  axis_cfg_t cfg,
  output logic      in_act,
  output logic      in_blk,
  output logic      in_sync,
  output logic      in_fp
);
  assign in_act  = (cnt <= cfg.act);
  assign in_blk  = (cnt >  cfg.bs) && (cnt <= cfg.be);
  assign in_sync = (cnt >= cfg.ss) && (cnt <  cfg.se);
  assign in_fp   = (cnt >= cfg.fs) && (cnt <  cfg.fe);
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DW     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic [CW-1:0]     hcount_o,
  output logic [CW-1:0]     vcount_o,
  output logic              de_o,
  output logic              blank_o,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              fp_hsync_o,
  output logic              fp_vsync_o
);
  localparam int unsigned VAX = NAX - 1;

  logic                ctrl_en;
  logic [1:0]          pol;
  axis_cfg_t [NAX-1:0] live;
  logic [NAX-1:0][CW-1:0] cnt;
  logic [NAX-1:0]      step;
  logic [NAX-1:0]      wrap;
  logic [NAX-1:0]      act_hit, blk_hit, sync_hit, fp_hit;
  pos_t                v_next;
  logic                xfer;

  rtg_regs #(.ADDR_W(ADDR_W), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(xfer), .ctrl_en(ctrl_en), .pol(pol), .live(live)
  );

  for (genvar a = 0; a < NAX; a++) begin : g_axis
    if (a == 0) begin : g_first
      assign step[a] = 1'b1;
    end else begin : g_chain
      assign step[a] = wrap[a-1];
    end
    rtg_axis_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst(rst), .run(ctrl_en), .step(step[a]),
      .tot(live[a].tot), .cnt(cnt[a]), .wrap(wrap[a])
    );
    rtg_axis_cmp u_cmp (
      .cnt(cnt[a]), .cfg(live[a]), .in_act(act_hit[a]), .in_blk(blk_hit[a]),
      .in_sync(sync_hit[a]), .in_fp(fp_hit[a])
    );
  end

  assign v_next = (cnt[VAX] == live[VAX].tot) ? '0 : cnt[VAX] + CW'(1);
  assign xfer   = !ctrl_en || (wrap[0] && (v_next == live[VAX].bs + CW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount_o   <= '0;
      vcount_o   <= '0;
      de_o       <= 1'b0;
      blank_o    <= 1'b0;
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      fp_hsync_o <= 1'b0;
      fp_vsync_o <= 1'b0;
    end else begin
      hcount_o   <= cnt[0];
      vcount_o   <= cnt[VAX];
      de_o       <= ctrl_en && (&act_hit);
      blank_o    <= ctrl_en && (|blk_hit);
      hsync_o    <= (ctrl_en && sync_hit[0])   ^ pol[0];
      vsync_o    <= (ctrl_en && sync_hit[VAX]) ^ pol[1];
      fp_hsync_o <= (ctrl_en && fp_hit[0])     ^ pol[0];
      fp_vsync_o <= (ctrl_en && fp_hit[VAX])   ^ pol[1];
    end
  end
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker
  import rtg_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic [1:0]          pol,
  input pos_t                h,
  input pos_t                v,
  input pos_t                htot,
  input logic                xfer,
  input axis_cfg_t [NAX-1:0] live,
  input pos_t                hcount_o,
  input logic                de_o,
  input logic                blank_o,
  input logic                hsync_o,
  input logic                vsync_o
);
  AST_H_BOUND: assert property (@(posedge clk) disable iff (rst) h <= htot); // R3
  AST_H_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (en && h != htot) |=> h == $past(h) + CW'(1)); // R3
  AST_V_HOLD: assert property (@(posedge clk) disable iff (rst)
    (en && h != htot) |=> $stable(v)); // R4
  AST_LIVE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (en && !xfer) |=> $stable(live)); // R9
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!de_o && !blank_o)); // R10
  AST_IDLE_SYNC_LEVEL: assert property (@(posedge clk) disable iff (rst)
    !en |=> (hsync_o == $past(pol[0]) && vsync_o == $past(pol[1]))); // R10
  AST_COUNT_ECHO: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> hcount_o == $past(h)); // R11
endmodule

bind raster_timing_gen rtg_checker u_chk (
  .clk(clk), .rst(rst), .en(ctrl_en), .pol(pol), .h(cnt[0]), .v(cnt[1]),
  .htot(live[0].tot), .xfer(xfer), .live(live), .hcount_o(hcount_o),
  .de_o(de_o), .blank_o(blank_o), .hsync_o(hsync_o), .vsync_o(vsync_o)
);

// File: tb/sim_raster_timing_gen.sv
module sim_raster_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [10:0] hcount_o, vcount_o;
  logic        de_o, blank_o, hsync_o, vsync_o, fp_hsync_o, fp_vsync_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;
  bit cmp_on = 0;

  // behavioural reference state
  int unsigned m_h, m_v;
  logic [31:0] m_reg [0:8];
  logic [31:0] m_live [1:8];
  int e_hc, e_vc, e_de, e_bl, e_hs, e_vs, e_fhs, e_fvs;

  always #10 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hcount_o(hcount_o), .vcount_o(vcount_o), .de_o(de_o), .blank_o(blank_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .fp_hsync_o(fp_hsync_o), .fp_vsync_o(fp_vsync_o)
  );

  function automatic int lo(input logic [31:0] r); return int'(r[10:0]); endfunction
  function automatic int hi(input logic [31:0] r); return int'(r[26:16]); endfunction
  function automatic logic [31:0] pk(input int l, input int h);
    return (32'(h) << 16) | 32'(l);
  endfunction
  function automatic int win(input int c, input int s, input int e);
    return (c >= s && c < e) ? 1 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    int en, p0, p1, vn;
    if (rst) begin
      m_h = 0; m_v = 0;
      for (int i = 0; i <= 8; i++) m_reg[i] = '0;
      for (int i = 1; i <= 8; i++) m_live[i] = '0;
      e_hc = 0; e_vc = 0; e_de = 0; e_bl = 0; e_hs = 0; e_vs = 0; e_fhs = 0; e_fvs = 0;
    end else begin
      en = int'(m_reg[0][0]); p0 = int'(m_reg[0][4]); p1 = int'(m_reg[0][5]);
      e_hc = int'(m_h); e_vc = int'(m_v);
      e_de = (en != 0 && m_h <= lo(m_live[1]) && m_v <= lo(m_live[5])) ? 1 : 0;
      e_bl = (en != 0 && ((m_h > lo(m_live[2]) && m_h <= hi(m_live[2])) ||
                          (m_v > lo(m_live[6]) && m_v <= hi(m_live[6])))) ? 1 : 0;
      e_hs  = (en & win(m_h, lo(m_live[3]), hi(m_live[3]))) ^ p0;
      e_fhs = (en & win(m_h, lo(m_live[4]), hi(m_live[4]))) ^ p0;
      e_vs  = (en & win(m_v, lo(m_live[7]), hi(m_live[7]))) ^ p1;
      e_fvs = (en & win(m_v, lo(m_live[8]), hi(m_live[8]))) ^ p1;
      if (en == 0) begin
        m_h = 0; m_v = 0;
        for (int i = 1; i <= 8; i++) m_live[i] = m_reg[i];
      end else if (m_h == hi(m_live[1])) begin
        m_h = 0;
        vn = (m_v == hi(m_live[5])) ? 0 : (m_v + 1) % 2048;
        if (vn == (lo(m_live[6]) + 1) % 2048)
          for (int i = 1; i <= 8; i++) m_live[i] = m_reg[i];
        m_v = vn;
      end else begin
        m_h = m_h + 1;
      end
      if (wr_en && wr_addr <= 4'd8) m_reg[wr_addr] = wr_data;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk("R3 hcount", int'(hcount_o), e_hc);
      chk("R4 vcount", int'(vcount_o), e_vc);
      chk("R5 de", int'(de_o), e_de);
      chk("R6 blank", int'(blank_o), e_bl);
      chk("R7 hsync", int'(hsync_o), e_hs);
      chk("R7 vsync", int'(vsync_o), e_vs);
      chk("R8 fp_hsync", int'(fp_hsync_o), e_fhs);
      chk("R8 fp_vsync", int'(fp_vsync_o), e_fvs);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL R11 watchdog expired actual=%0d expected<150000", cyc);
      finish_up();
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_v(input int val);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (int'(vcount_o) == val && int'(hcount_o) == 0) break;
    end
  endtask

  task automatic max_h(input int n, output int mx);
    mx = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (int'(hcount_o) > mx) mx = int'(hcount_o);
    end
  endtask

  initial begin
    int mx, cnt;
    repeat (3) @(negedge clk);
    cmp_on = 1;
    chk("R11 reset hcount", int'(hcount_o), 0);
    chk("R11 reset vcount", int'(vcount_o), 0);
    chk("R11 reset de", int'(de_o), 0);
    chk("R11 reset hsync", int'(hsync_o), 0);
    rst = 1'b0;

    // small mode: 10x6 visible in 16x9
    wr(1, pk(9, 15));  wr(2, pk(9, 15));  wr(3, pk(11, 13)); wr(4, pk(11, 14));
    wr(5, pk(5, 8));   wr(6, pk(5, 8));   wr(7, pk(6, 7));   wr(8, pk(5, 6));
    wr(0, 32'h1);
    repeat (450) @(negedge clk);

    // R2: both syncs active-low
    wr(0, 32'h31);
    wait_v(0);
    chk("R2 hsync idle level low-active", int'(hsync_o), 1);
    chk("R2 vsync idle level low-active", int'(vsync_o), 1);
    repeat (150) @(negedge clk);

    // R1: writes above address 8 are ignored
    wr(12, 32'hFFFF_FFFF); wr(15, 32'h0000_0000);
    max_h(40, mx);
    chk("R1 ignored address keeps line length", mx, 15);

    // R9: mid-frame change waits for vertical blanking
    wait_v(2);
    wr(1, pk(11, 19));
    max_h(20, mx);
    chk("R9 old line length kept mid-frame", mx, 15);
    wait_v(7);
    max_h(25, mx);
    chk("R9 new line length after blank start", mx, 19);
    repeat (400) @(negedge clk);

    // R10: disable
    wr(0, 32'h30);
    repeat (3) @(negedge clk);
    chk("R10 hcount held", int'(hcount_o), 0);
    chk("R10 vcount held", int'(vcount_o), 0);
    chk("R10 hsync inactive", int'(hsync_o), 1);
    chk("R10 fp_vsync inactive", int'(fp_vsync_o), 1);
    chk("R10 de low", int'(de_o), 0);

    // 640-wide line, 832 total, syncs active-low
    wr(1, pk(639, 831)); wr(2, pk(639, 831)); wr(3, pk(663, 703)); wr(4, pk(663, 703));
    wr(5, pk(2, 7));     wr(6, pk(2, 7));     wr(7, pk(4, 6));     wr(8, pk(3, 5));
    wr(0, 32'h31);
    repeat (900) @(negedge clk);
    cnt = 0;
    for (int i = 0; i < 832; i++) begin
      @(negedge clk);
      if (hsync_o == 1'b0) cnt++;
    end
    chk("R7 hsync pulse width pixels", cnt, 40);
    cnt = 0;
    for (int i = 0; i < 832 * 8; i++) begin
      @(negedge clk);
      if (fp_vsync_o == 1'b0 && vsync_o == 1'b1) cnt++;
    end
    chk("R8 flat-panel vsync leads by one line", cnt, 832);

    // 1688 total, active-high
    wr(0, 32'h30);
    wr(1, pk(1279, 1687)); wr(2, pk(1279, 1687)); wr(3, pk(1327, 1439)); wr(4, pk(1327, 1439));
    wr(0, 32'h1);
    cnt = 0;
    for (int i = 0; i < 1688 * 8 * 2; i++) begin
      @(negedge clk);
      if (hsync_o == 1'b1) cnt++;
    end
    chk("R7 active-high hsync cycles over two frames", cnt, 112 * 16);
    max_h(1700, mx);
    chk("R3 wide line wraps at stored total", mx, 1687);

    finish_up();
  end
endmodule